// File: doc/BRIEF.md
# Serial Register and Packet Buffer Access Port

This block is the serial slave through which a host processor reaches the control and status registers of a radio core and its two word-wide packet buffers. The host drives a serial clock, a data line toward the block and an active-low select line. Each transaction starts with one header byte that holds a direction flag and a six-bit address. The header is followed by one or more 16-bit words, each sent as two bytes with the most significant bit first. While select stays low, further words follow without a new header. For ordinary addresses the address steps by one after each word. The two buffer addresses instead stream consecutive buffer entries, always starting from entry zero.

The serial pins are brought into the system clock domain and edge-detected, so the serial clock must run well below the system clock. Register access uses plain strobes. A write strobe carries address and data. A read strobe expects the register value on `reg_rdata_i` in the same cycle. There is no back-pressure on either side: the register bank must accept a write and answer a read in the cycle of the strobe. The modem side of each buffer is a simple memory port, writable for the receive buffer and readable for the transmit buffer. A word written to address 0 produces a one-cycle core reset pulse. The buffers are not affected by that pulse.

Top module: `spi_reg_port`

## Requirements
- R1: No strobe is produced while select is high. The first byte after select falls is the header: bit 7 is the direction (1 = read, 0 = write), bits 5:0 are the address, and bit 6 is ignored.
- R2: Data is transferred MSB first. The block samples MOSI on rising serial clock edges and changes MISO on falling edges. The MSB of a read word is on MISO from the falling edge after the last header bit, and MISO stays low during the header.
- R3: After the 16th data bit of a write word to an ordinary address, exactly one `reg_wr_o` pulse is issued with that address and the assembled word.
- R4: A read header for an ordinary address raises `reg_rd_o` with that address when the header completes, and the value returned on `reg_rdata_i` is shifted out as the first word.
- R5: In a burst to an ordinary address, the address increases by one after every word and wraps from 63 to 0. This applies to both reads and writes.
- R6: A word cut short by select rising has no effect. No write or reset strobe is issued for it.
- R7: A write burst to address 2 fills transmit buffer entries 0, 1, 2, … in order, starting again at entry 0 in every such transaction. The modem reads the entries through `txb_raddr_i`/`txb_rdata_o`.
- R8: A read burst from address 1 returns receive buffer entries 0, 1, 2, … in order, starting again at entry 0 in every such transaction. The modem fills the entries through the `rxb_*` write port.
- R9: A complete word written to address 0 gives one `core_rst_o` pulse and no `reg_wr_o`. The contents of both buffers are kept.
- R10: While select is low, `spi_miso_oe_o` is 1. While select is high, `spi_miso_oe_o` equals the inverse of `miso_hiz_en_i` and `spi_miso_o` is 0.
- R11: After reset, no strobe is active and MISO behaves as in the idle case of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from host, idles low |
| spi_cs_n_i | input | 1 | Active-low transaction select |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad |
| miso_hiz_en_i | input | 1 | 1: release MISO when idle; 0: drive it low |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 6 | Register address for either strobe |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, valid in the cycle of `reg_rd_o` |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| rxb_we_i | input | 1 | Modem write enable, receive buffer |
| rxb_waddr_i | input | 6 | Modem write index, receive buffer |
| rxb_wdata_i | input | 16 | Modem write data, receive buffer |
| txb_raddr_i | input | 6 | Modem read index, transmit buffer |
| txb_rdata_o | output | 16 | Modem read data, transmit buffer |

## Verification
The assertions assume that the serial clock stays low whenever select changes and that each serial clock level lasts several system clocks, so that every synchronized edge is seen exactly once. They also assume that select changes only while the serial clock is low. The stimulus drives every serial level for six system clocks, moves MOSI only while the clock is low, and leaves idle margins around every select edge. The aborted-word cases end the transaction with the clock low as well.

// File: rtl/spi_rap_pkg.sv
package spi_rap_pkg;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;
  localparam logic [ADDR_W-1:0] ADDR_SWRST = 6'd0;
  localparam logic [ADDR_W-1:0] ADDR_RXBUF = 6'd1;
  localparam logic [ADDR_W-1:0] ADDR_TXBUF = 6'd2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_front.sv
module spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_bit
);
  logic [SYNC_STAGES-1:0] s_sclk, s_cs, s_mosi;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0;
      s_cs   <= '1;
      s_mosi <= '0;
      sclk_q <= 1'b0;
    end else begin
      s_sclk <= {s_sclk[SYNC_STAGES-2:0], sclk_i};
      s_cs   <= {s_cs[SYNC_STAGES-2:0], cs_n_i};
      s_mosi <= {s_mosi[SYNC_STAGES-2:0], mosi_i};
      sclk_q <= s_sclk[SYNC_STAGES-1];
    end
  end

  assign sclk_rise = s_sclk[SYNC_STAGES-1] & ~sclk_q;
  assign sclk_fall = ~s_sclk[SYNC_STAGES-1] & sclk_q;
  assign cs_act    = ~s_cs[SYNC_STAGES-1];
  assign mosi_bit  = s_mosi[SYNC_STAGES-1];
endmodule

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_rap_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  localparam int PW = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              mosi_bit,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              core_rst_o,
  output logic [PW-1:0]     rxb_raddr_o,
  input  logic [WORD_W-1:0] rxb_rdata_i,
  output logic              txb_we_o,
  output logic [PW-1:0]     txb_waddr_o,
  output logic [WORD_W-1:0] txb_wdata_o,
  output logic              miso_q_o
);
  phase_e              phase;
  logic [3:0]          bit_cnt;
  logic [WORD_W-1:0]   shreg, full, tx_sh;
  logic [ADDR_W-1:0]   addr;
  logic [PW-1:0]       ptr;
  logic                is_read, rx_stream, tx_stream, miso_q;
  logic                unit_done, hdr_done, word_done, hdr_read, hdr_rx;
  logic [ADDR_W-1:0]   hdr_addr;

  assign full      = {shreg[WORD_W-2:0], mosi_bit};
  assign hdr_read  = full[7];
  assign hdr_addr  = full[ADDR_W-1:0];
  assign hdr_rx    = hdr_read && (hdr_addr == ADDR_RXBUF);
  assign unit_done = cs_act && sclk_rise &&
                     ((phase == PH_HDR && bit_cnt == 4'd7) ||
                      (phase == PH_DATA && bit_cnt == 4'd15));
  assign hdr_done  = unit_done && (phase == PH_HDR);
  assign word_done = unit_done && (phase == PH_DATA);

  // Strobes are decoded from the word that completes on this rising edge.
  assign txb_we_o   = word_done && tx_stream;
  assign core_rst_o = word_done && !is_read && !tx_stream && (addr == ADDR_SWRST);
  assign reg_wr_o   = word_done && !is_read && !tx_stream && (addr != ADDR_SWRST);
  assign reg_rd_o   = (hdr_done && hdr_read && !hdr_rx) ||
                      (word_done && is_read && !rx_stream);
  assign reg_addr_o  = (phase == PH_HDR) ? hdr_addr : (is_read ? addr + 6'd1 : addr);
  assign reg_wdata_o = full;
  assign txb_waddr_o = ptr;
  assign txb_wdata_o = full;
  assign rxb_raddr_o = (phase == PH_HDR) ? '0 : ptr;
  assign miso_q_o    = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      addr      <= '0;
      ptr       <= '0;
      is_read   <= 1'b0;
      rx_stream <= 1'b0;
      tx_stream <= 1'b0;
      miso_q    <= 1'b0;
    end else if (!cs_act) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (phase == PH_IDLE) phase <= PH_HDR;
      if (sclk_rise && phase != PH_IDLE) begin
        shreg   <= full;
        bit_cnt <= unit_done ? 4'd0 : bit_cnt + 4'd1;
      end
      if (hdr_done) begin
        phase     <= PH_DATA;
        is_read   <= hdr_read;
        addr      <= hdr_addr;
        rx_stream <= hdr_rx;
        tx_stream <= !hdr_read && (hdr_addr == ADDR_TXBUF);
        ptr       <= hdr_rx ? PW'(1) : '0;
        if (hdr_read) tx_sh <= hdr_rx ? rxb_rdata_i : reg_rdata_i;
      end
      if (word_done) begin
        if (rx_stream) begin
          tx_sh <= rxb_rdata_i;
          ptr   <= ptr + PW'(1);
        end else if (tx_stream) begin
          ptr <= ptr + PW'(1);
        end else begin
          addr <= addr + 6'd1;
          if (is_read) tx_sh <= reg_rdata_i;
        end
      end
      if (sclk_fall && phase == PH_DATA && is_read) begin
        miso_q <= tx_sh[WORD_W-1];
        tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !(reg_wr_o || reg_rd_o || core_rst_o || txb_we_o));

  assert_miso_low_in_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR) |-> !miso_q);

  assert_write_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  assert_tx_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txb_we_o |=> (ptr == $past(ptr) + PW'(1)));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_o, core_rst_o, txb_we_o}));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_rap_pkg::*;
#(
  parameter int BUF_WORDS   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              miso_hiz_en_i,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              core_rst_o,
  input  logic              rxb_we_i,
  input  logic [PW-1:0]     rxb_waddr_i,
  input  logic [WORD_W-1:0] rxb_wdata_i,
  input  logic [PW-1:0]     txb_raddr_i,
  output logic [WORD_W-1:0] txb_rdata_o
);
  logic sclk_rise, sclk_fall, cs_act, mosi_bit, miso_q;
  logic [PW-1:0]     rxb_raddr, txb_waddr;
  logic [WORD_W-1:0] rxb_rdata, txb_wdata;
  logic              txb_we;

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk_i), .cs_n_i(spi_cs_n_i),
    .mosi_i(spi_mosi_i), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_bit(mosi_bit)
  );

  spi_txn_ctrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_bit(mosi_bit),
    .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i), .core_rst_o(core_rst_o),
    .rxb_raddr_o(rxb_raddr), .rxb_rdata_i(rxb_rdata),
    .txb_we_o(txb_we), .txb_waddr_o(txb_waddr), .txb_wdata_o(txb_wdata),
    .miso_q_o(miso_q)
  );

  pkt_buffer #(.DEPTH(BUF_WORDS), .W(WORD_W)) u_rx_buf (
    .clk(clk), .we(rxb_we_i), .waddr(rxb_waddr_i), .wdata(rxb_wdata_i),
    .raddr(rxb_raddr), .rdata(rxb_rdata)
  );

  pkt_buffer #(.DEPTH(BUF_WORDS), .W(WORD_W)) u_tx_buf (
    .clk(clk), .we(txb_we), .waddr(txb_waddr), .wdata(txb_wdata),
    .raddr(txb_raddr_i), .rdata(txb_rdata_o)
  );

  assign spi_miso_o    = cs_act & miso_q;
  assign spi_miso_oe_o = cs_act | ~miso_hiz_en_i;
endmodule

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, hiz = 1'b1;
  logic miso, miso_oe, reg_wr, reg_rd, core_rst;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        rxb_we = 1'b0;
  logic [5:0]  rxb_waddr = '0, txb_raddr = '0;
  logic [15:0] rxb_wdata = '0, txb_rdata;

  logic [15:0] regs [64];
  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] rd_words [$];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_reg_port uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .miso_hiz_en_i(hiz),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .core_rst_o(core_rst),
    .rxb_we_i(rxb_we), .rxb_waddr_i(rxb_waddr), .rxb_wdata_i(rxb_wdata),
    .txb_raddr_i(txb_raddr), .txb_rdata_o(txb_rdata)
  );

  assign reg_rdata = regs[reg_addr];

  function automatic logic [15:0] dflt(int a);
    return 16'h5A00 | 16'(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: register bank model plus scoreboard of write and reset strobes.
  always @(negedge clk) begin
    if (rst_n && (reg_wr || core_rst)) begin
      logic [23:0] got;
      got = {core_rst ? 2'd1 : 2'd0, reg_addr, reg_wdata};
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected strobe", 32'(got), 32'h0);
      else begin
        string t;
        logic [23:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, 32'(got), 32'(e));
      end
      if (core_rst) for (int a = 0; a < 64; a++) regs[a] = dflt(a);
      else regs[reg_addr] = reg_wdata;
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic spi_word(input logic [15:0] tx, output logic [15:0] rx);
    logic [7:0] hi, lo;
    spi_byte(tx[15:8], hi);
    spi_byte(tx[7:0], lo);
    rx = {hi, lo};
  endtask

  // Driver: write burst; pushes expected strobes into the scoreboard.
  task automatic wr_burst(input logic [7:0] hdr, input logic [15:0] base, input int n, input string tag);
    logic [7:0] d8;
    logic [15:0] d16;
    cs_begin();
    spi_byte(hdr, d8);
    for (int k = 0; k < n; k++) begin
      logic [5:0] a;
      a = hdr[5:0] + 6'(k);
      if (hdr[5:0] != 6'd2) begin
        exp_q.push_back({(a == 6'd0) ? 2'd1 : 2'd0, a, base + 16'(k)});
        tag_q.push_back(tag);
      end
      spi_word(base + 16'(k), d16);
    end
    cs_end();
  endtask

  task automatic rd_burst(input logic [7:0] hdr, input int n);
    logic [7:0] d8;
    logic [15:0] d16;
    rd_words.delete();
    cs_begin();
    spi_byte(hdr, d8);
    for (int k = 0; k < n; k++) begin
      spi_word(16'h0000, d16);
      rd_words.push_back(d16);
    end
    cs_end();
  endtask

  initial begin
    for (int a = 0; a < 64; a++) regs[a] = dflt(a);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 / R10 reset and idle state
    chk(!reg_wr && !reg_rd && !core_rst, "R11 strobes after reset", {reg_wr, reg_rd, core_rst}, 0);
    chk(miso_oe == 1'b0, "R10 idle release with hiz=1", miso_oe, 0);
    hiz = 1'b0;
    @(negedge clk);
    chk(miso_oe == 1'b1 && miso == 1'b0, "R10 idle driven low with hiz=0", {miso_oe, miso}, 2'b10);
    hiz = 1'b1;

    // R3 single write, R4 / R2 read back an asymmetric pattern
    wr_burst(8'h05, 16'h8E31, 1, "R3 single write");
    rd_burst(8'h85, 1);
    chk(rd_words[0] == 16'h8E31, "R4 R2 read back msb first", rd_words[0], 16'h8E31);

    // R10 enable while selected
    cs_begin();
    chk(miso_oe == 1'b1, "R10 enable while selected", miso_oe, 1);
    cs_end();

    // R6 aborted word and header-only transaction
    begin
      logic [7:0] d8;
      cs_begin(); spi_byte(8'h05, d8); spi_byte(8'hFF, d8); cs_end();
      cs_begin(); spi_byte(8'h05, d8); cs_end();
    end
    rd_burst(8'h85, 1);
    chk(rd_words[0] == 16'h8E31, "R6 aborted word left register", rd_words[0], 16'h8E31);

    // R5 burst write and wrapping burst read
    wr_burst(8'h3D, 16'h1230, 3, "R5 burst write");
    rd_burst(8'hBE, 3);
    chk(rd_words[0] == 16'h1231, "R5 burst read 62", rd_words[0], 16'h1231);
    chk(rd_words[1] == 16'h1232, "R5 burst read 63", rd_words[1], 16'h1232);
    chk(rd_words[2] == dflt(0), "R5 burst read wraps to 0", rd_words[2], dflt(0));

    // R1 header bit 6 ignored
    wr_burst(8'h47, 16'h7001, 1, "R1 bit6 ignored on write");
    rd_burst(8'hC7, 1);
    chk(rd_words[0] == 16'h7001, "R1 bit6 ignored on read", rd_words[0], 16'h7001);

    // R7 transmit buffer streaming
    wr_burst(8'h02, 16'hC0DE, 3, "R7");
    for (int k = 0; k < 3; k++) begin
      txb_raddr = 6'(k);
      @(negedge clk);
      chk(txb_rdata == 16'hC0DE + 16'(k), "R7 tx entry", txb_rdata, 16'hC0DE + 16'(k));
    end
    wr_burst(8'h02, 16'hBEEF, 1, "R7");
    txb_raddr = 6'd0; @(negedge clk);
    chk(txb_rdata == 16'hBEEF, "R7 tx pointer restarts at 0", txb_rdata, 16'hBEEF);
    txb_raddr = 6'd1; @(negedge clk);
    chk(txb_rdata == 16'hC0DF, "R7 tx entry 1 untouched", txb_rdata, 16'hC0DF);
    chk(exp_q.size() == 0, "R7 no register strobe for tx stream", exp_q.size(), 0);

    // R8 receive buffer streaming
    for (int k = 0; k < 4; k++) begin
      rxb_we = 1'b1; rxb_waddr = 6'(k); rxb_wdata = 16'hA100 + 16'(k * 17);
      @(negedge clk);
    end
    rxb_we = 1'b0;
    rd_burst(8'h81, 4);
    for (int k = 0; k < 4; k++)
      chk(rd_words[k] == 16'hA100 + 16'(k * 17), "R8 rx entry", rd_words[k], 16'hA100 + 16'(k * 17));
    rd_burst(8'h81, 2);
    chk(rd_words[0] == 16'hA100 && rd_words[1] == 16'hA111, "R8 rx pointer restarts at 0",
        {rd_words[0], rd_words[1]}, {16'hA100, 16'hA111});

    // R9 core reset keeps buffers
    wr_burst(8'h07, 16'h3C3C, 1, "R9 setup write");
    wr_burst(8'h00, 16'h0000, 1, "R9 reset pulse");
    rd_burst(8'h87, 1);
    chk(rd_words[0] == dflt(7), "R9 register default after reset", rd_words[0], dflt(7));
    txb_raddr = 6'd1; @(negedge clk);
    chk(txb_rdata == 16'hC0DF, "R9 tx buffer kept", txb_rdata, 16'hC0DF);
    rd_burst(8'h81, 1);
    chk(rd_words[0] == 16'hA100, "R9 rx buffer kept", rd_words[0], 16'hA100);

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule